// File: doc/BRIEF.md
# Measurement Round Scheduler

This block paces sample requests across up to four sensing points that share one measurement controller. The points are visited in rounds. Within a round each enabled point is sampled a programmed number of times before the scheduler moves on to the next enabled point in ascending index order. After the last enabled point, the scheduler rests for a while and then starts the next round.

All waiting is expressed in ticks of a programmable time base. One tick lasts `period_unit × 256` clock cycles. Three separate tick counts set the spacing between requests:

- the spacing between samples of the same point;
- the spacing when moving from one point to the next;
- the rest between rounds.

The scheduler emits a one-cycle request strobe together with a point index. It also raises a round-done flag in the same cycle as the final request of each round. Consumers that perform the conversion, filtering or limit checks attach to these strobes.

Top module: `meas_round_sched`

## Requirements
- R1: A tick lasts max(period_unit_i, 1) × 256 clock cycles, so a period unit of 0 behaves as 1. A spacing of N ticks places the next request strobe N × tick + 1 cycles after the previous strobe.
- R2: Two consecutive requests to the same point are spaced by filt_ivl_i ticks.
- R3: The last request to one point and the first request to the next enabled point of the same round are spaced by sens_ivl_i ticks.
- R4: round_done_o is high only in the cycle of the last request of a round. The first request of the next round follows grp_ivl_i ticks later.
- R5: Bit i of en_map_i enables point i. Within a round, points are requested in ascending index order with disabled points skipped, and every round begins at the lowest enabled point.
- R6: Point i is sampled samp_m1_i[5i+4:5i] + 1 times per round, and all of those samples are consecutive.
- R7: While en_map_i reads all zero at a round start, no request is issued. The first request follows in the first cycle in which the map is nonzero.
- R8: The enable map and the sample counts are captured when a round starts. Changes made during a round first affect the next round.
- R9: A spacing of 0 ticks issues the next request on the immediately following clock cycle.
- R10: While rst_n is low, req_o and round_done_o are low. With a nonzero map, the first request is issued in the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_map_i | input | 4 | Point enable map, bit i for point i |
| period_unit_i | input | 10 | Time-base multiplier, in units of 256 cycles |
| filt_ivl_i | input | 10 | Ticks between samples of one point |
| sens_ivl_i | input | 10 | Ticks between adjacent enabled points |
| grp_ivl_i | input | 10 | Ticks between rounds |
| samp_m1_i | input | 20 | Samples per point minus one, 5 bits per point |
| req_o | output | 1 | One-cycle sample request strobe |
| req_idx_o | output | 2 | Point index of the current request |
| round_done_o | output | 1 | High with the last request of a round |

## Verification
A corrupted gap counter shows up as a request strobe that arrives early or late, measured against the previous strobe. The mismatch is visible at the very next request, so every spacing is checked as a cycle difference between consecutive strobes. A wrong point pointer or a wrong remaining-sample count shows up as an out-of-order index, or as a round_done_o flag on the wrong strobe, within the same round. A map captured at the wrong moment shows up only at the following round boundary, which is why the mid-round map change is followed through into the next round.

// File: rtl/rsched_pkg.sv
`timescale 1ns/1ps
package rsched_pkg;

  typedef enum logic {
    ST_START = 1'b0,
    ST_RUN   = 1'b1
  } rs_state_e;

  typedef enum logic [1:0] {
    GAP_FILT = 2'd0,
    GAP_SENS = 2'd1,
    GAP_GRP  = 2'd2
  } gap_kind_e;

  // Cycles of silence after a request: interval ticks of max(pu,1) << log2s cycles.
  function automatic logic [47:0] gap_cycles(input logic [15:0] ivl,
                                             input logic [15:0] pu,
                                             input int unsigned log2s);
    logic [47:0] pu_eff;
    pu_eff = (pu == 16'd0) ? 48'd1 : 48'(pu);
    return (48'(ivl) * pu_eff) << log2s;
  endfunction

  // Which spacing follows a request, given what remains in the round.
  function automatic gap_kind_e gap_pick(input logic more_same, input logic next_found);
    if (more_same)       return GAP_FILT;
    else if (next_found) return GAP_SENS;
    else                 return GAP_GRP;
  endfunction

endpackage

// File: rtl/rsched_gap_timer.sv
`timescale 1ns/1ps
module rsched_gap_timer #(
  parameter int IVL_W     = 10,
  parameter int TICK_LOG2 = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [IVL_W-1:0] ivl_i,
  input  logic [IVL_W-1:0] pu_i,
  output logic             expired_o
);
  import rsched_pkg::*;

  localparam int CNT_W = 2 * IVL_W + TICK_LOG2;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= CNT_W'(gap_cycles(16'(ivl_i), 16'(pu_i), TICK_LOG2));
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);

  // R9: a zero interval leaves the timer expired on the next cycle
  a_r9_zero_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && ivl_i == '0) |=> expired_o);

  // R1: a nonzero interval always produces at least 256 quiet cycles
  a_r1_nonzero_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && ivl_i != '0) |=> !expired_o);

endmodule

// File: rtl/rsched_pick.sv
`timescale 1ns/1ps
module rsched_pick #(
  parameter int N_SENS = 4,
  parameter int IDX_W  = 2
) (
  input  logic [N_SENS-1:0] map_i,
  input  logic [IDX_W-1:0]  after_i,
  input  logic              after_en_i,
  output logic              found_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [N_SENS-1:0] cand;

  for (genvar g = 0; g < N_SENS; g++) begin : g_cand
    assign cand[g] = map_i[g] &
                     (!after_en_i || ((IDX_W+1)'(g) > {1'b0, after_i}));
  end

  always_comb begin
    idx_o = '0;
    for (int i = N_SENS - 1; i >= 0; i--) begin
      if (cand[i]) idx_o = IDX_W'(i);
    end
  end

  assign found_o = |cand;

endmodule

// File: rtl/meas_round_sched.sv
`timescale 1ns/1ps
module meas_round_sched #(
  parameter int N_SENS    = 4,
  parameter int IVL_W     = 10,
  parameter int SAMP_W    = 5,
  parameter int TICK_LOG2 = 8,
  localparam int IDX_W    = (N_SENS > 1) ? $clog2(N_SENS) : 1,
  localparam int SMAP_W   = N_SENS * SAMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SENS-1:0] en_map_i,
  input  logic [IVL_W-1:0]  period_unit_i,
  input  logic [IVL_W-1:0]  filt_ivl_i,
  input  logic [IVL_W-1:0]  sens_ivl_i,
  input  logic [IVL_W-1:0]  grp_ivl_i,
  input  logic [SMAP_W-1:0] samp_m1_i,
  output logic              req_o,
  output logic [IDX_W-1:0]  req_idx_o,
  output logic              round_done_o
);
  import rsched_pkg::*;

  function automatic logic [SAMP_W-1:0] field_of(input logic [SMAP_W-1:0] v,
                                                 input logic [IDX_W-1:0] i);
    return v[32'(i) * SAMP_W +: SAMP_W];
  endfunction

  rs_state_e          state_q;
  logic [IDX_W-1:0]   cur_idx_q;
  logic [SAMP_W-1:0]  left_q;
  logic [N_SENS-1:0]  map_q;
  logic [SMAP_W-1:0]  samp_q;

  // named internal events
  logic               timer_expired;
  logic               first_found;
  logic [IDX_W-1:0]   first_idx;
  logic               start_fire;
  logic               run_fire;
  logic               fire;
  logic [IDX_W-1:0]   fire_idx;
  logic [N_SENS-1:0]  map_eff;
  logic [SMAP_W-1:0]  samp_eff;
  logic [SAMP_W-1:0]  rem;
  logic               more_same;
  logic               next_found;
  logic [IDX_W-1:0]   next_idx;
  logic               last_of_round;
  gap_kind_e          gap_kind;
  logic [IVL_W-1:0]   gap_ivl;

  rsched_gap_timer #(.IVL_W(IVL_W), .TICK_LOG2(TICK_LOG2)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (fire),
    .ivl_i     (gap_ivl),
    .pu_i      (period_unit_i),
    .expired_o (timer_expired)
  );

  // lowest enabled point of the live map, for a round start
  rsched_pick #(.N_SENS(N_SENS), .IDX_W(IDX_W)) u_pick_first (
    .map_i      (en_map_i),
    .after_i    ('0),
    .after_en_i (1'b0),
    .found_o    (first_found),
    .idx_o      (first_idx)
  );

  // next enabled point above the one being requested now
  rsched_pick #(.N_SENS(N_SENS), .IDX_W(IDX_W)) u_pick_next (
    .map_i      (map_eff),
    .after_i    (fire_idx),
    .after_en_i (1'b1),
    .found_o    (next_found),
    .idx_o      (next_idx)
  );

  assign start_fire = rst_n && (state_q == ST_START) && timer_expired && first_found;
  assign run_fire   = rst_n && (state_q == ST_RUN) && timer_expired;
  assign fire       = start_fire || run_fire;

  assign fire_idx  = start_fire ? first_idx : cur_idx_q;
  assign map_eff   = start_fire ? en_map_i  : map_q;
  assign samp_eff  = start_fire ? samp_m1_i : samp_q;
  assign rem       = start_fire ? field_of(samp_m1_i, first_idx) : left_q;
  assign more_same = (rem != '0);
  assign last_of_round = !more_same && !next_found;

  assign gap_kind = gap_pick(more_same, next_found);

  always_comb begin
    unique case (gap_kind)
      GAP_FILT: gap_ivl = filt_ivl_i;
      GAP_SENS: gap_ivl = sens_ivl_i;
      default:  gap_ivl = grp_ivl_i;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_START;
      cur_idx_q <= '0;
      left_q    <= '0;
      map_q     <= '0;
      samp_q    <= '0;
    end else begin
      if (start_fire) begin
        map_q  <= en_map_i;
        samp_q <= samp_m1_i;
      end
      if (fire) begin
        if (last_of_round) begin
          state_q <= ST_START;
        end else begin
          state_q <= ST_RUN;
        end
        if (more_same) begin
          cur_idx_q <= fire_idx;
          left_q    <= rem - 1'b1;
        end else begin
          cur_idx_q <= next_idx;
          left_q    <= field_of(samp_eff, next_idx);
        end
      end
    end
  end

  assign req_o        = fire;
  assign req_idx_o    = fire_idx;
  assign round_done_o = fire && last_of_round;

  // bookkeeping used only by the ordering property
  logic             in_round_q;
  logic [IDX_W-1:0] prev_idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_round_q <= 1'b0;
      prev_idx_q <= '0;
    end else if (req_o) begin
      in_round_q <= !round_done_o;
      prev_idx_q <= req_idx_o;
    end
  end

  // R5: indices never go down inside a round
  a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && in_round_q) |-> (req_idx_o >= prev_idx_q));

  // R5: every request targets a point enabled for this round
  a_r5_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> map_eff[req_idx_o]);

  // R4: round end flag only accompanies a request
  a_r4_done_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    round_done_o |-> req_o);

  // R4: no request while a spacing is still running
  a_r4_quiet_gap: assert property (@(posedge clk) disable iff (!rst_n)
    !timer_expired |-> !req_o);

  // R7: an empty map at a round start issues nothing
  a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_START) && (en_map_i == '0)) |-> !req_o);

  // R8: the captured map only moves at a round start
  a_r8_hold_map: assert property (@(posedge clk) disable iff (!rst_n)
    !start_fire |=> $stable(map_q));

endmodule

// File: tb/meas_round_sched_bench.sv
`timescale 1ns/1ps
module meas_round_sched_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  en_map = '0;
  logic [9:0]  pu = '0, f_ivl = '0, s_ivl = '0, g_ivl = '0;
  logic [19:0] samp = '0;
  logic        req_o, round_done_o;
  logic [1:0]  req_idx_o;

  always #2 clk = ~clk;

  meas_round_sched u_meas_round_sched (
    .clk(clk), .rst_n(rst_n), .en_map_i(en_map), .period_unit_i(pu),
    .filt_ivl_i(f_ivl), .sens_ivl_i(s_ivl), .grp_ivl_i(g_ivl),
    .samp_m1_i(samp), .req_o(req_o), .req_idx_o(req_idx_o),
    .round_done_o(round_done_o)
  );

  // stimulus / expected table
  localparam int NV = 6;
  localparam logic [3:0]  V_MAP [NV] = '{4'hF, 4'h5, 4'h8, 4'h6, 4'hB, 4'h1};
  localparam int          V_PU  [NV] = '{1, 1, 2, 0, 1, 1};
  localparam int          V_F   [NV] = '{0, 1, 0, 2, 0, 3};
  localparam int          V_S   [NV] = '{0, 2, 5, 1, 1, 0};
  localparam int          V_G   [NV] = '{0, 3, 1, 0, 2, 0};
  localparam logic [19:0] V_SM  [NV] = '{20'h0, {5'd0, 5'd2, 5'd0, 5'd1},
                                         {5'd3, 15'd0}, {5'd0, 5'd1, 5'd0, 5'd0},
                                         20'h0, 20'h0};
  localparam int          V_REQ [NV] = '{4, 5, 4, 3, 3, 1};
  localparam int          V_PER [NV] = '{4, 2053, 516, 771, 1027, 1};

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  int cyc = 0;

  // request log
  int ev_t [64];
  int ev_i [64];
  bit ev_d [64];
  int n_ev = 0;
  bit log_en = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (log_en && req_o && n_ev < 64) begin
      ev_t[n_ev] = cyc;
      ev_i[n_ev] = int'(req_idx_o);
      ev_d[n_ev] = round_done_o;
      n_ev++;
    end
  end

  // model of the expected sequence
  int    x_i   [64];
  int    x_gap [64];
  bit    x_d   [64];
  string x_tag [64];
  int    nx;

  function automatic int spacing(int ivl, int p);
    int tick;
    tick = (p == 0) ? 256 : p * 256;
    return ivl * tick + 1;
  endfunction

  task automatic build_model(input logic [3:0] m, input int p, input int f,
                             input int s, input int g, input logic [19:0] sm,
                             input int rounds);
    int prev_s, prev_r;
    nx = 0; prev_s = -1; prev_r = -1;
    for (int r = 0; r < rounds; r++) begin
      for (int si = 0; si < 4; si++) begin
        if (m[si]) begin
          for (int k = 0; k <= int'(sm[5*si +: 5]); k++) begin
            x_i[nx] = si;
            x_d[nx] = 1'b0;
            if (nx == 0)               begin x_gap[nx] = 0;               x_tag[nx] = "R10"; end
            else if (prev_r != r)      begin x_gap[nx] = spacing(g, p);  x_tag[nx] = "R4"; end
            else if (prev_s == si)     begin x_gap[nx] = spacing(f, p);  x_tag[nx] = "R2"; end
            else                       begin x_gap[nx] = spacing(s, p);  x_tag[nx] = "R3"; end
            prev_s = si; prev_r = r;
            nx++;
          end
        end
      end
      x_d[nx-1] = 1'b1;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic start_cfg(input logic [3:0] m, input int p, input int f,
                           input int s, input int g, input logic [19:0] sm);
    @(posedge clk); #1;
    rst_n = 1'b0; log_en = 1'b0; n_ev = 0;
    en_map = m; pu = 10'(p); f_ivl = 10'(f); s_ivl = 10'(s); g_ivl = 10'(g);
    samp = sm;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1; log_en = 1'b1;
  endtask

  task automatic compare_log();
    chk(n_ev >= nx, "R6", "request count", n_ev, nx);
    for (int e = 0; e < nx && e < n_ev; e++) begin
      chk(ev_i[e] == x_i[e], "R5", "point index", ev_i[e], x_i[e]);
      chk(ev_d[e] == x_d[e], "R4", "round_done flag", int'(ev_d[e]), int'(x_d[e]));
      if (e > 0)
        chk(ev_t[e] - ev_t[e-1] == x_gap[e], x_tag[e], "spacing",
            ev_t[e] - ev_t[e-1], x_gap[e]);
    end
  endtask

  initial begin
    // R10: reset holds the outputs low even with every point enabled
    @(posedge clk); #1;
    rst_n = 1'b0; en_map = 4'hF; pu = 10'd1;
    repeat (4) @(negedge clk);
    chk(req_o == 1'b0, "R10", "req_o in reset", int'(req_o), 0);
    chk(round_done_o == 1'b0, "R10", "round_done_o in reset", int'(round_done_o), 0);

    // R10: first request right after release, at the lowest enabled point
    start_cfg(4'b0110, 1, 1, 1, 1, 20'h0);
    #1;
    chk(req_o == 1'b1, "R10", "req_o after release", int'(req_o), 1);
    chk(req_idx_o == 2'd1, "R10", "first index", int'(req_idx_o), 1);

    // table walk: R1 R2 R3 R4 R5 R6 R9
    for (int k = 0; k < NV; k++) begin
      start_cfg(V_MAP[k], V_PU[k], V_F[k], V_S[k], V_G[k], V_SM[k]);
      repeat (2 * V_PER[k] + 10) @(posedge clk);
      build_model(V_MAP[k], V_PU[k], V_F[k], V_S[k], V_G[k], V_SM[k], 2);
      compare_log();
      if (n_ev > V_REQ[k]) begin
        chk(ev_t[V_REQ[k]] - ev_t[0] == V_PER[k], "R1", "round period",
            ev_t[V_REQ[k]] - ev_t[0], V_PER[k]);
        chk(ev_d[V_REQ[k]-1] == 1'b1, "R4", "last of round flagged",
            int'(ev_d[V_REQ[k]-1]), 1);
      end else begin
        chk(1'b0, "R1", "round period (too few requests)", n_ev, V_REQ[k] + 1);
      end
    end

    // R7: empty map stays idle
    start_cfg(4'h0, 1, 0, 0, 0, 20'h0);
    repeat (600) @(posedge clk);
    chk(n_ev == 0, "R7", "requests with empty map", n_ev, 0);
    @(posedge clk); #1;
    en_map = 4'b0100;
    #1;
    chk(req_o == 1'b1, "R7", "request once map set", int'(req_o), 1);
    chk(req_idx_o == 2'd2, "R7", "index once map set", int'(req_idx_o), 2);

    // R8: map and counts changed mid-round apply next round
    start_cfg(4'h5, 1, 1, 2, 3, {5'd0, 5'd2, 5'd0, 5'd1});
    while (n_ev < 1) @(negedge clk);
    @(posedge clk); #1;
    en_map = 4'b0010; samp = 20'h0;
    repeat (2100) @(posedge clk);
    chk(n_ev == 6, "R8", "request count across change", n_ev, 6);
    begin
      int exp_idx [6] = '{0, 0, 2, 2, 2, 1};
      for (int e = 0; e < 6 && e < n_ev; e++)
        chk(ev_i[e] == exp_idx[e], "R8", "index across change", ev_i[e], exp_idx[e]);
    end
    if (n_ev >= 6) begin
      chk(ev_d[4] == 1'b1, "R8", "old round still ends at point 2", int'(ev_d[4]), 1);
      chk(ev_d[5] == 1'b1, "R8", "new single-sample round done", int'(ev_d[5]), 1);
      chk(ev_t[5] - ev_t[4] == 769, "R8", "group spacing", ev_t[5] - ev_t[4], 769);
    end

    // R7: map cleared mid-round lets the round finish, then idles
    start_cfg(4'hB, 1, 0, 1, 2, 20'h0);
    while (n_ev < 1) @(negedge clk);
    @(posedge clk); #1;
    en_map = 4'h0;
    repeat (2000) @(posedge clk);
    chk(n_ev == 3, "R7", "requests after clearing map", n_ev, 3);
    @(negedge clk);
    chk(req_o == 1'b0, "R7", "idle after cleared map", int'(req_o), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule